// File: doc/BRIEF.md
# Packet-Mode I2C Transfer Sequencer

This block sits between a 32-bit transmit FIFO and a byte-level I2C bus engine. It treats the words it pops as self-describing transfer packets. Each packet opens with three header words. The first is a tag word whose content the sequencer does not use. The second carries the byte count. The third carries the target address, the direction, the addressing mode, the end-of-transfer policy and the completion-event enable. Write packets follow the header with payload words.

The sequencer turns each packet into a series of engine commands: bus start, one or two address bytes, data writes or reads, and then the closing condition. Received bytes are packed into 32-bit words for a receive FIFO. A NACK or a lost arbitration aborts the packet cleanly, so the FIFO stays aligned on the next header. Packet completion, NACK and arbitration loss are signalled to an interrupt unit as single-cycle pulses.

Top module: `i2c_pkt_decoder`

## Requirements
- R1: A packet is read as three header words popped in order. The byte count is bits [CNT_W-1:0] of the second word plus one. The content of the first word is ignored.
- R2: A packet that does not follow a repeated-start or continue ending begins with a START command. It then writes the address byte {hdr2[7:1], read}, where read is hdr2 bit 19. The `cmd_op` codes are 0 START, 1 WRITE, 2 READ, 3 STOP and 4 repeated start.
- R3: When hdr2 bit 18 is set, the address is hdr2[9:0]. It is sent as two bytes: {5'b11110, a[9:8], read} followed by a[7:0].
- R4: Write payload bytes are sent lowest byte of each word first. Exactly the counted number of bytes is sent, so the unused upper bytes of a partial final word never reach the bus.
- R5: A read packet issues one READ per counted byte, with `cmd_last` high only on the final one. Received bytes fill receive words from the lowest byte upward. A partial final word is zero-padded and pushed.
- R6: A packet that completes normally closes with STOP by default. It closes with a repeated start when hdr2 bit 16 is set. It issues no closing command when hdr2 bit 15 is set, and bit 15 takes priority over bit 16.
- R7: After a repeated-start ending, the next packet omits START. After a continue ending, the next packet omits both START and its address bytes.
- R8: A NACK on an address or write byte with hdr2 bit 21 clear has four effects. It raises `ev_nack`, pops and discards the packet's remaining payload words, and issues STOP. The following packet then starts with START.
- R9: When hdr2 bit 21 is set, a NACK is ignored: no event is raised and the transfer proceeds byte by byte.
- R10: Arbitration loss raises `ev_arb_lost` and discards the remaining payload words. It issues no closing command. The following packet starts with START.
- R11: `ev_pkt_done` pulses once after the closing condition of a packet that completed without abort, and only if hdr2 bit 17 is set.
- R12: A pending command keeps its op, byte and last flag stable until acknowledged. The FIFO is popped only when it is non-empty and never while a command is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txf_valid | input | 1 | Transmit FIFO holds a word |
| txf_data | input | 32 | Transmit FIFO head word |
| txf_pop | output | 1 | Consume the head word this cycle |
| cmd_req | output | 1 | Command pending toward the bus engine |
| cmd_op | output | 3 | Command code (see R2) |
| cmd_byte | output | 8 | Byte for WRITE commands |
| cmd_last | output | 1 | Final READ of the packet (engine answers NACK) |
| cmd_ack | input | 1 | Engine has finished the pending command |
| cmd_nack | input | 1 | Target did not acknowledge, valid with cmd_ack |
| cmd_arb_lost | input | 1 | Arbitration lost, valid with cmd_ack |
| cmd_rdata | input | 8 | Byte read, valid with cmd_ack on READ |
| rxf_push | output | 1 | Push one word to the receive FIFO |
| rxf_data | output | 32 | Word pushed to the receive FIFO |
| ev_pkt_done | output | 1 | Packet-complete pulse |
| ev_nack | output | 1 | Aborting NACK pulse |
| ev_arb_lost | output | 1 | Arbitration-loss pulse |

## Verification
The fragile internal state is the payload word counter and the carry of the continuation flags from one packet to the next. If the counter drifts by one word after an abort, the next header is parsed from payload data. That shows at the command port within a few cycles as a wrong START, address byte or count. A stale continuation flag shows as a missing or extra START in the very next packet. For this reason every abort scenario is followed directly by a normal packet whose full command stream is compared. Byte-lane or padding errors in the receive packer show on the first pushed word.

// File: rtl/i2cp_pkg.sv
package i2cp_pkg;

    localparam int WORD_W = 32;
    localparam int LANES  = WORD_W / 8;

    // hdr2 control bit positions
    localparam int HB_CONT_NAK = 21;
    localparam int HB_READ     = 19;
    localparam int HB_TEN      = 18;
    localparam int HB_IRQ      = 17;
    localparam int HB_RS_END   = 16;
    localparam int HB_CONT_END = 15;

    typedef enum logic [2:0] {
        OP_START  = 3'd0,
        OP_WRITE  = 3'd1,
        OP_READ   = 3'd2,
        OP_STOP   = 3'd3,
        OP_RSTART = 3'd4
    } cmd_op_e;

    typedef enum logic [3:0] {
        ST_HDR0, ST_HDR1, ST_HDR2, ST_START, ST_ADDR_HI,
        ST_ADDR_LO, ST_DATA, ST_DRAIN, ST_END, ST_FINISH
    } seq_state_e;

    typedef enum logic [1:0] {
        END_STOP, END_RSTART, END_NONE
    } end_kind_e;

    typedef struct packed {
        logic       cont_nak;
        logic       rd;
        logic       ten;
        logic       irq_en;
        logic       rs_end;
        logic       cont_end;
        logic [9:0] addr;
    } xfer_cfg_t;

    function automatic xfer_cfg_t decode_cfg(input logic [WORD_W-1:0] w);
        xfer_cfg_t c;
        c.cont_nak = w[HB_CONT_NAK];
        c.rd       = w[HB_READ];
        c.ten      = w[HB_TEN];
        c.irq_en   = w[HB_IRQ];
        c.rs_end   = w[HB_RS_END];
        c.cont_end = w[HB_CONT_END];
        c.addr     = w[9:0];
        return c;
    endfunction

    function automatic logic [7:0] first_addr_byte(input xfer_cfg_t c);
        if (c.ten)
            return {5'b11110, c.addr[9:8], c.rd};
        return {c.addr[7:1], c.rd};
    endfunction

    function automatic end_kind_e pick_end(input xfer_cfg_t c, input logic aborted);
        if (aborted)    return END_STOP;
        if (c.cont_end) return END_NONE;
        if (c.rs_end)   return END_RSTART;
        return END_STOP;
    endfunction

endpackage

// File: rtl/i2cp_tx_unpack.sv
module i2cp_tx_unpack
    import i2cp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              load,
    input  logic [WORD_W-1:0] word_in,
    input  logic              adv,
    output logic              have,
    output logic [7:0]        byte_out
);
    localparam int IDX_W = $clog2(LANES);

    logic [WORD_W-1:0] word_q;
    logic [IDX_W-1:0]  idx_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            have  <= 1'b0;
            idx_q <= '0;
            if (rst) word_q <= '0;
        end else if (load) begin
            word_q <= word_in;
            have   <= 1'b1;
            idx_q  <= '0;
        end else if (adv) begin
            if (idx_q == IDX_W'(LANES - 1)) have <= 1'b0;
            idx_q <= idx_q + 1'b1;
        end
    end

    assign byte_out = word_q[{idx_q, 3'b000} +: 8];

endmodule

// File: rtl/i2cp_rx_pack.sv
module i2cp_rx_pack
    import i2cp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              put,
    input  logic [7:0]        byte_in,
    input  logic              last,
    output logic              push,
    output logic [WORD_W-1:0] data
);
    localparam int IDX_W = $clog2(LANES);

    logic [WORD_W-1:0] acc_q, acc_nxt;
    logic [IDX_W-1:0]  idx_q;

    always_comb begin
        acc_nxt = acc_q;
        acc_nxt[{idx_q, 3'b000} +: 8] = byte_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            idx_q <= '0;
            push  <= 1'b0;
            data  <= '0;
        end else begin
            push <= 1'b0;
            if (clr) begin
                acc_q <= '0;
                idx_q <= '0;
            end else if (put) begin
                if (last || idx_q == IDX_W'(LANES - 1)) begin
                    data  <= acc_nxt;
                    push  <= 1'b1;
                    acc_q <= '0;
                    idx_q <= '0;
                end else begin
                    acc_q <= acc_nxt;
                    idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/i2c_pkt_decoder.sv
module i2c_pkt_decoder
    import i2cp_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        txf_valid,
    input  logic [31:0] txf_data,
    output logic        txf_pop,
    output logic        cmd_req,
    output logic [2:0]  cmd_op,
    output logic [7:0]  cmd_byte,
    output logic        cmd_last,
    input  logic        cmd_ack,
    input  logic        cmd_nack,
    input  logic        cmd_arb_lost,
    input  logic [7:0]  cmd_rdata,
    output logic        rxf_push,
    output logic [31:0] rxf_data,
    output logic        ev_pkt_done,
    output logic        ev_nack,
    output logic        ev_arb_lost
);
    localparam int REM_W = CNT_W + 1;
    localparam int WL_W  = CNT_W - 1;

    seq_state_e      state;
    xfer_cfg_t       cfg;
    logic [REM_W-1:0] rem;
    logic [WL_W-1:0]  words_left, words_need;
    logic [REM_W:0]   rem_pad;
    logic            skip_start, skip_addr;
    logic            ab_nack, ab_arb;
    logic            ev_done_q, ev_nack_q, ev_arb_q;

    cmd_op_e         op_sel;
    end_kind_e       end_kind;
    logic            ack_seen, resp_arb, resp_nack;
    logic            tx_flush, tx_load, tx_adv, tx_have;
    logic [7:0]      tx_byte;
    logic            rx_put;

    assign rem_pad    = {1'b0, rem} + (REM_W+1)'(3);
    assign words_need = WL_W'(rem_pad >> 2);
    assign end_kind   = pick_end(cfg, ab_nack);
    assign ack_seen   = cmd_req && cmd_ack;

    assign resp_arb  = ack_seen && cmd_arb_lost &&
                       (state inside {ST_START, ST_ADDR_HI, ST_ADDR_LO, ST_DATA});
    assign resp_nack = ack_seen && cmd_nack && !cfg.cont_nak &&
                       ((state inside {ST_ADDR_HI, ST_ADDR_LO}) ||
                        (state == ST_DATA && !cfg.rd));

    // command and FIFO strobes
    always_comb begin
        txf_pop  = 1'b0;
        cmd_req  = 1'b0;
        op_sel   = OP_START;
        cmd_byte = 8'h00;
        cmd_last = 1'b0;
        tx_load  = 1'b0;
        unique case (state)
            ST_HDR0, ST_HDR1, ST_HDR2: txf_pop = txf_valid;
            ST_START: cmd_req = 1'b1;
            ST_ADDR_HI: begin
                cmd_req  = 1'b1;
                op_sel   = OP_WRITE;
                cmd_byte = first_addr_byte(cfg);
            end
            ST_ADDR_LO: begin
                cmd_req  = 1'b1;
                op_sel   = OP_WRITE;
                cmd_byte = cfg.addr[7:0];
            end
            ST_DATA: begin
                if (cfg.rd) begin
                    cmd_req  = 1'b1;
                    op_sel   = OP_READ;
                    cmd_last = (rem == REM_W'(1));
                end else if (!tx_have) begin
                    txf_pop = txf_valid;
                    tx_load = txf_valid;
                end else begin
                    cmd_req  = 1'b1;
                    op_sel   = OP_WRITE;
                    cmd_byte = tx_byte;
                end
            end
            ST_DRAIN: txf_pop = txf_valid && (words_left != '0);
            ST_END: begin
                if (end_kind != END_NONE) begin
                    cmd_req = 1'b1;
                    op_sel  = (end_kind == END_RSTART) ? OP_RSTART : OP_STOP;
                end
            end
            default: ;
        endcase
    end

    assign cmd_op   = op_sel;
    assign tx_flush = (state == ST_HDR2);
    assign tx_adv   = ack_seen && state == ST_DATA && !cfg.rd;
    assign rx_put   = ack_seen && state == ST_DATA && cfg.rd && !resp_arb;

    i2cp_tx_unpack u_unpack (
        .clk      (clk),
        .rst      (rst),
        .flush    (tx_flush),
        .load     (tx_load),
        .word_in  (txf_data),
        .adv      (tx_adv),
        .have     (tx_have),
        .byte_out (tx_byte)
    );

    i2cp_rx_pack u_pack (
        .clk     (clk),
        .rst     (rst),
        .clr     (resp_arb),
        .put     (rx_put),
        .byte_in (cmd_rdata),
        .last    (cmd_last),
        .push    (rxf_push),
        .data    (rxf_data)
    );

    // sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_HDR0;
            cfg        <= '0;
            rem        <= '0;
            words_left <= '0;
            skip_start <= 1'b0;
            skip_addr  <= 1'b0;
            ab_nack    <= 1'b0;
            ab_arb     <= 1'b0;
            ev_done_q  <= 1'b0;
            ev_nack_q  <= 1'b0;
            ev_arb_q   <= 1'b0;
        end else begin
            ev_done_q <= 1'b0;
            ev_nack_q <= 1'b0;
            ev_arb_q  <= 1'b0;
            if (txf_pop && (state inside {ST_DATA, ST_DRAIN}))
                words_left <= words_left - 1'b1;

            if (resp_arb) begin
                ev_arb_q <= 1'b1;
                ab_arb   <= 1'b1;
                state    <= ST_DRAIN;
            end else if (resp_nack) begin
                ev_nack_q <= 1'b1;
                ab_nack   <= 1'b1;
                state     <= ST_DRAIN;
            end else begin
                unique case (state)
                    ST_HDR0: if (txf_valid) state <= ST_HDR1;
                    ST_HDR1: if (txf_valid) begin
                        rem   <= REM_W'(txf_data[CNT_W-1:0]) + REM_W'(1);
                        state <= ST_HDR2;
                    end
                    ST_HDR2: if (txf_valid) begin
                        cfg        <= decode_cfg(txf_data);
                        words_left <= txf_data[HB_READ] ? '0 : words_need;
                        ab_nack    <= 1'b0;
                        ab_arb     <= 1'b0;
                        skip_start <= 1'b0;
                        skip_addr  <= 1'b0;
                        if (skip_addr)       state <= ST_DATA;
                        else if (skip_start) state <= ST_ADDR_HI;
                        else                 state <= ST_START;
                    end
                    ST_START:   if (ack_seen) state <= ST_ADDR_HI;
                    ST_ADDR_HI: if (ack_seen) state <= cfg.ten ? ST_ADDR_LO : ST_DATA;
                    ST_ADDR_LO: if (ack_seen) state <= ST_DATA;
                    ST_DATA: if (ack_seen) begin
                        rem <= rem - 1'b1;
                        if (rem == REM_W'(1)) state <= ST_END;
                    end
                    ST_DRAIN: if (words_left == '0)
                        state <= ab_arb ? ST_FINISH : ST_END;
                    ST_END: if (end_kind == END_NONE || ack_seen) state <= ST_FINISH;
                    ST_FINISH: begin
                        ev_done_q  <= cfg.irq_en && !(ab_nack || ab_arb);
                        skip_start <= !(ab_nack || ab_arb) && cfg.rs_end && !cfg.cont_end;
                        skip_addr  <= !(ab_nack || ab_arb) && cfg.cont_end;
                        state      <= ST_HDR0;
                    end
                    default: state <= ST_HDR0;
                endcase
            end
        end
    end

    assign ev_pkt_done = ev_done_q;
    assign ev_nack     = ev_nack_q;
    assign ev_arb_lost = ev_arb_q;

endmodule

// File: rtl/i2cp_checker.sv
module i2cp_checker
    import i2cp_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       txf_valid,
    input logic       txf_pop,
    input logic       cmd_req,
    input logic [2:0] cmd_op,
    input logic [7:0] cmd_byte,
    input logic       cmd_last,
    input logic       cmd_ack,
    input logic       cmd_nack,
    input logic       cmd_arb_lost,
    input logic       rxf_push,
    input logic       ev_pkt_done,
    input logic       ev_nack,
    input logic       ev_arb_lost
);

    a_r12_pop_needs_data: assert property (@(posedge clk) disable iff (rst)
        txf_pop |-> txf_valid);

    a_r12_no_pop_while_cmd: assert property (@(posedge clk) disable iff (rst)
        cmd_req |-> !txf_pop);

    a_r12_cmd_held: assert property (@(posedge clk) disable iff (rst)
        (cmd_req && !cmd_ack) |=> (cmd_req && $stable(cmd_op) &&
                                   $stable(cmd_byte) && $stable(cmd_last)));

    a_r8_nack_has_cause: assert property (@(posedge clk) disable iff (rst)
        ev_nack |-> $past(cmd_req && cmd_ack && cmd_nack));

    a_r10_arb_has_cause: assert property (@(posedge clk) disable iff (rst)
        ev_arb_lost |-> $past(cmd_req && cmd_ack && cmd_arb_lost));

    a_r11_events_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ev_pkt_done, ev_nack, ev_arb_lost}));

    a_r5_push_after_read: assert property (@(posedge clk) disable iff (rst)
        rxf_push |-> $past(cmd_req && cmd_ack && cmd_op == OP_READ));

endmodule

bind i2c_pkt_decoder i2cp_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .txf_valid    (txf_valid),
    .txf_pop      (txf_pop),
    .cmd_req      (cmd_req),
    .cmd_op       (cmd_op),
    .cmd_byte     (cmd_byte),
    .cmd_last     (cmd_last),
    .cmd_ack      (cmd_ack),
    .cmd_nack     (cmd_nack),
    .cmd_arb_lost (cmd_arb_lost),
    .rxf_push     (rxf_push),
    .ev_pkt_done  (ev_pkt_done),
    .ev_nack      (ev_nack),
    .ev_arb_lost  (ev_arb_lost)
);

// File: tb/i2c_pkt_decoder_test.sv
`timescale 1ns/1ps
module i2c_pkt_decoder_test;
    import i2cp_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic        txf_valid = 1'b0;
    logic [31:0] txf_data = '0;
    logic        txf_pop;
    logic        cmd_req, cmd_last;
    logic [2:0]  cmd_op;
    logic [7:0]  cmd_byte;
    logic        cmd_ack = 1'b0, cmd_nack = 1'b0, cmd_arb_lost = 1'b0;
    logic [7:0]  cmd_rdata = '0;
    logic        rxf_push;
    logic [31:0] rxf_data;
    logic        ev_pkt_done, ev_nack, ev_arb_lost;

    i2c_pkt_decoder uut (
        .clk(clk), .rst(rst),
        .txf_valid(txf_valid), .txf_data(txf_data), .txf_pop(txf_pop),
        .cmd_req(cmd_req), .cmd_op(cmd_op), .cmd_byte(cmd_byte), .cmd_last(cmd_last),
        .cmd_ack(cmd_ack), .cmd_nack(cmd_nack), .cmd_arb_lost(cmd_arb_lost),
        .cmd_rdata(cmd_rdata),
        .rxf_push(rxf_push), .rxf_data(rxf_data),
        .ev_pkt_done(ev_pkt_done), .ev_nack(ev_nack), .ev_arb_lost(ev_arb_lost)
    );

    typedef struct {
        logic [2:0] op;
        logic [7:0] b;
        logic       last;
        logic       nack;
        logic       arb;
        logic [7:0] rd;
        string      tag;
    } ecmd_t;

    logic [31:0] txq[$];
    ecmd_t       cq[$];
    logic [31:0] rq[$];
    ecmd_t       e;

    int n_chk = 0, n_fail = 0;
    int got_done = 0, got_nack = 0, got_arb = 0;
    int exp_done = 0, exp_nack = 0, exp_arb = 0;
    int wait_cnt = 0;
    bit prev_rs = 0, prev_cont = 0;
    logic pop_seen = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] dbyte(input int i);
        return 8'((8'h31 + i * 7) & 8'hFF);
    endfunction

    function automatic logic [7:0] rbyte(input int i);
        return 8'((8'hA5 ^ (i * 13)) & 8'hFF);
    endfunction

    always @(posedge clk) pop_seen <= txf_pop;

    // FIFO, engine and output monitors, all at the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            if (pop_seen && txq.size() > 0) void'(txq.pop_front());
            txf_valid = (txq.size() > 0);
            txf_data  = (txq.size() > 0) ? txq[0] : 32'h0;

            if (cmd_ack) begin
                cmd_ack = 1'b0;
                cmd_nack = 1'b0;
                cmd_arb_lost = 1'b0;
                if (cq.size() > 0) void'(cq.pop_front());
                wait_cnt = 0;
            end else if (cmd_req) begin
                wait_cnt++;
                if (wait_cnt >= 2) begin
                    if (cq.size() == 0) begin
                        chk(0, "R12", "unexpected command", cmd_op, 7);
                    end else begin
                        e = cq[0];
                        chk(cmd_op == e.op, e.tag, "command op", cmd_op, e.op);
                        if (e.op == OP_WRITE)
                            chk(cmd_byte == e.b, e.tag, "write byte", cmd_byte, e.b);
                        if (e.op == OP_READ)
                            chk(cmd_last == e.last, e.tag, "read last flag", cmd_last, e.last);
                        cmd_nack = e.nack;
                        cmd_arb_lost = e.arb;
                        cmd_rdata = e.rd;
                    end
                    cmd_ack = 1'b1;
                end
            end

            if (rxf_push) begin
                if (rq.size() == 0) chk(0, "R5", "unexpected rx word", rxf_data, 0);
                else begin
                    chk(rxf_data == rq[0], "R5", "rx word", rxf_data, rq[0]);
                    void'(rq.pop_front());
                end
            end
            if (ev_pkt_done) got_done++;
            if (ev_nack) got_nack++;
            if (ev_arb_lost) got_arb++;
        end
    end

    task automatic add(input logic [2:0] op, input logic [7:0] b, input logic last,
                       input logic nk, input logic ar, input logic [7:0] rd, input string tag);
        ecmd_t x;
        x.op = op; x.b = b; x.last = last; x.nack = nk; x.arb = ar; x.rd = rd; x.tag = tag;
        cq.push_back(x);
    endtask

    // endm: 0 stop, 1 repeated start, 2 continue. nak_at/arb_at index address+write bytes.
    task automatic pkt(input int n, input bit rd, input bit ten, input int adr, input bit ie,
                       input int endm, input bit cnak, input int nak_at, input int arb_at,
                       input string tag);
        logic [31:0] h2, w;
        logic [7:0]  ab;
        int pos = 0, k = 0;
        bit ab_n = 0, ab_a = 0;
        txq.push_back(32'h0001_0010 | (32'(n) << 24));
        txq.push_back(32'(n - 1));
        h2 = '0;
        h2[21] = cnak; h2[19] = rd; h2[18] = ten; h2[17] = ie;
        h2[16] = (endm == 1); h2[15] = (endm == 2);
        if (ten) h2[9:0] = 10'(adr); else h2[7:1] = 7'(adr);
        if (!rd) begin
            for (int i = 0; i < (n + 3) / 4; i++) begin
                w = 32'hEEEE_EEEE;
                for (int j = 0; j < 4; j++)
                    if (i * 4 + j < n) w[j*8 +: 8] = dbyte(i * 4 + j);
                txq.push_back(w);
            end
        end
        txq.push_back(h2);
        // header order: move h2 ahead of payload
        if (!rd) begin
            logic [31:0] tmp[$];
            int np = (n + 3) / 4;
            for (int i = 0; i < np + 1; i++) tmp.push_front(txq.pop_back());
            txq.push_back(tmp[np]);
            for (int i = 0; i < np; i++) txq.push_back(tmp[i]);
        end
        if (!prev_rs && !prev_cont) add(OP_START, 0, 0, 0, 0, 0, "R2");
        if (!prev_cont) begin
            ab = ten ? {5'b11110, 2'(adr >> 8), rd} : {7'(adr), rd};
            add(OP_WRITE, ab, 0, pos == nak_at, pos == arb_at, 0, ten ? "R3" : "R2");
            if (pos == arb_at) ab_a = 1; else if (pos == nak_at && !cnak) ab_n = 1;
            pos++;
            if (ten && !ab_n && !ab_a) begin
                add(OP_WRITE, 8'(adr), 0, pos == nak_at, pos == arb_at, 0, "R3");
                if (pos == arb_at) ab_a = 1; else if (pos == nak_at && !cnak) ab_n = 1;
                pos++;
            end
        end
        w = '0;
        for (int i = 0; i < n && !ab_n && !ab_a; i++) begin
            if (rd) begin
                add(OP_READ, 0, i == n - 1, 0, 0, rbyte(i), "R5");
                w[k*8 +: 8] = rbyte(i);
                k++;
                if (k == 4 || i == n - 1) begin rq.push_back(w); w = '0; k = 0; end
            end else begin
                add(OP_WRITE, dbyte(i), 0, pos == nak_at, pos == arb_at, 0,
                    (pos == nak_at) ? (cnak ? "R9" : "R8") : "R4");
                if (pos == arb_at) ab_a = 1; else if (pos == nak_at && !cnak) ab_n = 1;
                pos++;
            end
        end
        if (ab_n) add(OP_STOP, 0, 0, 0, 0, 0, "R8");
        else if (!ab_a) begin
            if (endm == 0) add(OP_STOP, 0, 0, 0, 0, 0, "R6");
            else if (endm == 1) add(OP_RSTART, 0, 0, 0, 0, 0, "R6");
        end
        if (ab_n) exp_nack++;
        if (ab_a) exp_arb++;
        if (ie && !ab_n && !ab_a) exp_done++;
        prev_rs   = !ab_n && !ab_a && endm == 1;
        prev_cont = !ab_n && !ab_a && endm == 2;
        while (cq.size() != 0 || txq.size() != 0) @(negedge clk);
        repeat (12) @(negedge clk);
        chk(got_done == exp_done, "R11", {tag, " done events"}, got_done, exp_done);
        chk(got_nack == exp_nack, "R8", {tag, " nack events"}, got_nack, exp_nack);
        chk(got_arb == exp_arb, "R10", {tag, " arb events"}, got_arb, exp_arb);
        chk(rq.size() == 0, "R5", {tag, " rx words outstanding"}, rq.size(), 0);
        chk(cmd_req == 1'b0, "R1", {tag, " idle after packet"}, cmd_req, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(cmd_req == 1'b0 && txf_pop == 1'b0, "R12", "reset: no request", cmd_req, 0);
        chk(rxf_push == 1'b0, "R5", "reset: no push", rxf_push, 0);
        chk({ev_pkt_done, ev_nack, ev_arb_lost} == 3'b000, "R11", "reset: no events",
            {ev_pkt_done, ev_nack, ev_arb_lost}, 0);
        rst = 1'b0;
        repeat (6) @(negedge clk);
        chk(cmd_req == 1'b0, "R1", "empty FIFO stays idle", cmd_req, 0);

        pkt(5, 0, 0, 'h52, 1, 0, 0, -1, -1, "R4 partial write");
        pkt(6, 1, 0, 'h13, 1, 0, 0, -1, -1, "R5 read padded");
        pkt(4, 0, 1, 'h2A5, 0, 1, 0, -1, -1, "R3 ten-bit rs");
        pkt(3, 0, 0, 'h52, 1, 2, 0, -1, -1, "R7 after rs");
        pkt(2, 1, 0, 'h52, 1, 0, 0, -1, -1, "R7 after continue");
        pkt(9, 0, 0, 'h44, 1, 0, 0, 3, -1, "R8 data nack");
        pkt(2, 0, 0, 'h44, 1, 0, 1, 1, -1, "R9 nack ignored");
        pkt(6, 0, 0, 'h21, 1, 0, 0, -1, 2, "R10 arb lost");
        pkt(1, 1, 1, 'h3F0, 1, 0, 0, -1, -1, "R3 ten-bit read");
        pkt(3, 1, 0, 'h33, 1, 0, 0, 0, -1, "R8 address nack");
        pkt(8, 0, 0, 'h10, 1, 1, 0, -1, -1, "R4 full words");
        pkt(4, 1, 0, 'h10, 1, 2, 0, -1, -1, "R6 read continue");
        pkt(1, 0, 0, 'h10, 0, 0, 0, -1, -1, "R6 single byte");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R12 watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule